// File: doc/BRIEF.md
# Converter Host Bus Interface

This block sits between a successive-approximation conversion engine and a microprocessor bus that uses memory-style active-low chip select, read and write strobes. A write strobe while the chip is selected asks the engine to start a conversion. The block keeps an end-of-conversion flag that is low while a conversion runs. When the engine reports completion, the block holds the 12-bit code and the overrange bit in an output register.

The host reads that register either as two bytes on an 8-bit bus or as one word on a 16-bit bus. A byte-select address bit and a bus-width select input steer the reads. Output enables for the two byte lanes stand in for three-state buffers. The high lane carries the overrange bit beside the four most significant code bits.

A write that arrives while a conversion is running restarts the engine. A completion that arrives while the host is reading is held back until the read ends, so the host never sees the value change during a read.

Top module: `adc_host_port`

## Requirements
- R1: After reset, `eoc` is 1, `eng_start` is 0, `oe_low` and `oe_high` are 0, and `data_out` is 0.
- R2: Each assertion of the selected write (`cs_n` and `wr_n` both low) produces exactly one `eng_start` pulse, one clock wide, however long the write is held.
- R3: While `cs_n` is high, `wr_n` has no effect: no `eng_start` pulse occurs and `eoc` stays 1.
- R4: `eoc` goes to 0 on the clock edge that follows the `eng_start` pulse. This is 1 to 2 clock periods after the selected write begins.
- R5: An `eng_done` pulse accepted while a conversion runs (and no read is active) sets `eoc` to 1 on the next edge. On that same edge `data_out` becomes `{3'b000, ovr, code}`: the overrange bit is at bit 12, code bits 11..8 are at bits 11..8, and code bits 7..0 are at bits 7..0.
- R6: An `eng_done` pulse while `eoc` is 1 is ignored: `data_out` and `eoc` do not change.
- R7: A selected write while `eoc` is 0 restarts the conversion. `eoc` stays 0 until the engine reports completion of the new conversion, and the result captured is the new one.
- R8: With `cs_n`=0, `rd_n`=0 and `bus_wide`=0, the lane selection follows `byte_sel`. `byte_sel`=0 gives `oe_low`=1 and `oe_high`=0 (low byte, `data_out[7:0]`). `byte_sel`=1 gives `oe_high`=1 and `oe_low`=0 (high byte, `data_out[15:8]`).
- R9: With `cs_n`=0, `rd_n`=0 and `bus_wide`=1, both enables are 1 whatever `byte_sel` is.
- R10: When `rd_n` is 1 or `cs_n` is 1, both enables are 0.
- R11: If the engine completes while a read is active (either enable high), `data_out` and `eoc` do not change during the read. The held result is committed, and `eoc` rises, on the first clock edge at which no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; starts a conversion |
| byte_sel | input | 1 | Byte select for narrow reads: 0 low byte, 1 high byte |
| bus_wide | input | 1 | Bus width: 1 enables both lanes together |
| eng_done | input | 1 | Completion pulse from the conversion engine |
| eng_code | input | 12 | Code from the engine, valid with `eng_done` |
| eng_ovr | input | 1 | Overrange from the engine, valid with `eng_done` |
| eng_start | output | 1 | One-cycle start request to the engine |
| eoc | output | 1 | End of conversion: 0 busy, 1 result ready |
| data_out | output | 16 | Held result `{3'b000, ovr, code}` |
| oe_low | output | 1 | Enable for the low byte lane |
| oe_high | output | 1 | Enable for the high byte lane |

## Verification
The hardest case to reach from the ports is an engine completion that lands while the host holds a read open. Here the result must wait in the pending register with `eoc` still low. The bench starts a conversion and then opens a narrow read at once. It keeps the read open past the engine's fixed latency, and it checks that nothing moves until the read is released. The restart case is forced the same way: a second write is issued part way through the engine's latency. The scoreboard then receives only the second code.

// File: rtl/ahp_pkg.sv
package ahp_pkg;

    localparam int CODE_W = 12;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int PAD_W  = WORD_W - CODE_W - 1;

    typedef struct packed {
        logic              ovr;
        logic [CODE_W-1:0] code;
    } result_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HOLD = 2'd2
    } conv_state_e;

    function automatic logic [WORD_W-1:0] pack_word(input result_t r);
        return {{PAD_W{1'b0}}, r.ovr, r.code};
    endfunction

endpackage

// File: rtl/ahp_cmd_sync.sv
module ahp_cmd_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_raw,
    output logic start_pulse
);
    logic [STAGES:0] chain;
    logic            last_q;

    assign chain[0] = req_raw;

    generate
        for (genvar i = 1; i <= STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES];
    end

    assign start_pulse = chain[STAGES] & ~last_q;
endmodule

// File: rtl/ahp_conv_ctrl.sv
module ahp_conv_ctrl
    import ahp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    done,
    input  logic    rd_busy,
    input  result_t res_in,
    output logic    eoc,
    output result_t res_q
);
    conv_state_e state;
    result_t     pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            res_q  <= '0;
            pend_q <= '0;
        end else if (start) begin
            state <= ST_BUSY;
        end else begin
            case (state)
                ST_BUSY: begin
                    if (done) begin
                        if (rd_busy) begin
                            pend_q <= res_in;
                            state  <= ST_HOLD;
                        end else begin
                            res_q <= res_in;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!rd_busy) begin
                        res_q <= pend_q;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign eoc = (state == ST_IDLE);
endmodule

// File: rtl/ahp_lane_dec.sv
module ahp_lane_dec (
    input  logic cs_n,
    input  logic rd_n,
    input  logic byte_sel,
    input  logic bus_wide,
    output logic oe_low,
    output logic oe_high
);
    logic rd_act;

    always_comb begin
        rd_act  = ~cs_n & ~rd_n;
        oe_low  = rd_act & (bus_wide | ~byte_sel);
        oe_high = rd_act & (bus_wide |  byte_sel);
    end
endmodule

// File: rtl/adc_host_port.sv
module adc_host_port
    import ahp_pkg::*;
#(
    parameter int SYNC_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              byte_sel,
    input  logic              bus_wide,
    input  logic              eng_done,
    input  logic [CODE_W-1:0] eng_code,
    input  logic              eng_ovr,
    output logic              eng_start,
    output logic              eoc,
    output logic [WORD_W-1:0] data_out,
    output logic              oe_low,
    output logic              oe_high
);
    result_t eng_res;
    result_t held_res;
    logic    wr_sel;

    assign wr_sel       = ~cs_n & ~wr_n;
    assign eng_res.ovr  = eng_ovr;
    assign eng_res.code = eng_code;

    ahp_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .req_raw     (wr_sel),
        .start_pulse (eng_start)
    );

    ahp_lane_dec u_lane (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .byte_sel (byte_sel),
        .bus_wide (bus_wide),
        .oe_low   (oe_low),
        .oe_high  (oe_high)
    );

    ahp_conv_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (eng_start),
        .done    (eng_done),
        .rd_busy (oe_low | oe_high),
        .res_in  (eng_res),
        .eoc     (eoc),
        .res_q   (held_res)
    );

    assign data_out = pack_word(held_res);
endmodule

// File: rtl/ahp_checker.sv
module ahp_checker (
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        rd_n,
    input logic        bus_wide,
    input logic        eng_start,
    input logic        eng_done,
    input logic        eoc,
    input logic [15:0] data_out,
    input logic        oe_low,
    input logic        oe_high
);
    a_r2_single_start: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    a_r4_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eoc);

    a_r5_rise_not_after_start: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc) |-> !$past(eng_start));

    a_r6_idle_done_ignored: assert property (@(posedge clk) disable iff (rst)
        (eoc && eng_done && !eng_start) |=> (eoc && $stable(data_out)));

    a_r9_wide_both: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n && bus_wide) |-> (oe_low && oe_high));

    a_r10_no_read_no_enable: assert property (@(posedge clk) disable iff (rst)
        (rd_n || cs_n) |-> !(oe_low || oe_high));

    a_r11_stable_in_read: assert property (@(posedge clk) disable iff (rst)
        ((oe_low || oe_high) && $past(oe_low || oe_high)) |-> $stable(data_out));
endmodule

bind adc_host_port ahp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .bus_wide  (bus_wide),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .eoc       (eoc),
    .data_out  (data_out),
    .oe_low    (oe_low),
    .oe_high   (oe_high)
);

// File: tb/sim_adc_host_port.sv
`timescale 1ns/1ps
module sim_adc_host_port;
    localparam int LAT = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, rd_n, wr_n, byte_sel, bus_wide;
    logic        eng_done, eng_done_r, force_done;
    logic [11:0] model_code;
    logic        model_ovr;
    logic        eng_start, eoc, oe_low, oe_high;
    logic [15:0] data_out;

    always #10 clk = ~clk;

    adc_host_port u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .byte_sel(byte_sel), .bus_wide(bus_wide), .eng_done(eng_done),
        .eng_code(model_code), .eng_ovr(model_ovr), .eng_start(eng_start),
        .eoc(eoc), .data_out(data_out), .oe_low(oe_low), .oe_high(oe_high)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int start_cnt = 0;
    bit finished = 0;
    logic [15:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // engine model: fixed latency, restart on a new start
    int eng_cnt;
    logic eng_busy;
    always @(posedge clk) begin
        if (rst) begin
            eng_busy   <= 1'b0;
            eng_cnt    <= 0;
            eng_done_r <= 1'b0;
        end else begin
            eng_done_r <= 1'b0;
            if (eng_start) begin
                eng_busy <= 1'b1;
                eng_cnt  <= LAT;
            end else if (eng_busy) begin
                if (eng_cnt == 1) begin
                    eng_done_r <= 1'b1;
                    eng_busy   <= 1'b0;
                end
                eng_cnt <= eng_cnt - 1;
            end
        end
    end
    assign eng_done = eng_done_r | force_done;

    always @(posedge clk) if (!rst && eng_start) start_cnt++;

    // monitor: compare held result on every rise of eoc
    logic eoc_prev = 1'b1;
    always @(negedge clk) begin
        if (!rst && eoc && !eoc_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected completion", {16'h0, data_out}, 32'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(data_out == e, "R5 captured result", {16'h0, data_out}, {16'h0, e});
            end
        end
        eoc_prev = eoc;
    end

    task automatic pulse_wr(input int hold);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic wait_eoc();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (eoc) return;
        end
        chk(1'b0, "R5 eoc never rose", 32'h0, 32'h1);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        byte_sel = 1'b0; bus_wide = 1'b0; force_done = 1'b0;
        model_code = '0; model_ovr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(eoc == 1'b1, "R1 eoc", eoc, 1);
        chk(eng_start == 1'b0, "R1 eng_start", eng_start, 0);
        chk({oe_low, oe_high} == 2'b00, "R1 enables", {oe_low, oe_high}, 0);
        chk(data_out == 16'h0, "R1 data_out", data_out, 0);

        // R3: write with chip deselected
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(start_cnt == 0, "R3 no start", start_cnt, 0);
        chk(eoc == 1'b1, "R3 eoc stays high", eoc, 1);
        wr_n = 1'b1;

        // R2/R4: first conversion, long write
        model_code = 12'hA5C; model_ovr = 1'b0;
        exp_q.push_back(16'h0A5C);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        chk(eng_start == 1'b1, "R4 start after one edge", eng_start, 1);
        @(negedge clk);
        chk(eoc == 1'b0, "R4 eoc low within two periods", eoc, 0);
        chk(eng_start == 1'b0, "R2 start one cycle wide", eng_start, 0);
        repeat (4) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        chk(start_cnt == 1, "R2 single start for long write", start_cnt, 1);
        wait_eoc();

        // R8 narrow reads
        cs_n = 1'b0; rd_n = 1'b0; bus_wide = 1'b0; byte_sel = 1'b0; #1;
        chk({oe_low, oe_high} == 2'b10, "R8 low lane", {oe_low, oe_high}, 2'b10);
        chk(data_out[7:0] == 8'h5C, "R8 low byte", data_out[7:0], 8'h5C);
        byte_sel = 1'b1; #1;
        chk({oe_low, oe_high} == 2'b01, "R8 high lane", {oe_low, oe_high}, 2'b01);
        chk(data_out[15:8] == 8'h0A, "R8 high byte", data_out[15:8], 8'h0A);
        // R10
        rd_n = 1'b1; #1;
        chk({oe_low, oe_high} == 2'b00, "R10 rd high", {oe_low, oe_high}, 0);
        cs_n = 1'b1; rd_n = 1'b0; bus_wide = 1'b1; #1;
        chk({oe_low, oe_high} == 2'b00, "R10 cs high", {oe_low, oe_high}, 0);
        // R9 wide reads
        cs_n = 1'b0; byte_sel = 1'b0; #1;
        chk({oe_low, oe_high} == 2'b11, "R9 wide a0=0", {oe_low, oe_high}, 2'b11);
        byte_sel = 1'b1; #1;
        chk({oe_low, oe_high} == 2'b11, "R9 wide a0=1", {oe_low, oe_high}, 2'b11);
        cs_n = 1'b1; rd_n = 1'b1; bus_wide = 1'b0; byte_sel = 1'b0;

        // R5 with overrange
        model_code = 12'h01F; model_ovr = 1'b1;
        exp_q.push_back(16'h101F);
        pulse_wr(1);
        wait_eoc();
        chk(data_out[12] == 1'b1, "R5 overrange at bit 12", data_out[12], 1);

        // R7 restart mid conversion
        model_code = 12'h333; model_ovr = 1'b0;
        base = start_cnt;
        pulse_wr(1);
        repeat (8) @(negedge clk);
        model_code = 12'h7C4;
        exp_q.push_back(16'h07C4);
        pulse_wr(1);
        repeat (LAT - 2) @(negedge clk);
        chk(eoc == 1'b0, "R7 eoc held low after restart", eoc, 0);
        wait_eoc();
        chk(start_cnt == base + 2, "R7 two starts", start_cnt, base + 2);
        chk(data_out == 16'h07C4, "R7 new result", data_out, 16'h07C4);

        // R6 done while idle
        model_code = 12'hFFF; model_ovr = 1'b1;
        @(negedge clk); force_done = 1'b1;
        @(negedge clk); force_done = 1'b0;
        @(negedge clk);
        chk(data_out == 16'h07C4, "R6 data unchanged", data_out, 16'h07C4);
        chk(eoc == 1'b1, "R6 eoc unchanged", eoc, 1);

        // R11 completion during an open read
        model_code = 12'h5A5; model_ovr = 1'b0;
        exp_q.push_back(16'h05A5);
        pulse_wr(1);
        cs_n = 1'b0; rd_n = 1'b0; byte_sel = 1'b0;
        repeat (LAT + 5) @(negedge clk);
        chk(eoc == 1'b0, "R11 eoc held during read", eoc, 0);
        chk(data_out == 16'h07C4, "R11 data held during read", data_out, 16'h07C4);
        rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        chk(eoc == 1'b1, "R11 eoc after read", eoc, 1);
        chk(data_out == 16'h05A5, "R11 commit after read", data_out, 16'h05A5);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule